// File: doc/BRIEF.md
# Successive-Approximation Converter Control Register Block

This block gives a host processor a small set of memory-mapped registers for operating a multi-channel successive-approximation ADC core. The host turns the converter on, picks one of 32 inputs and one of four input ranges, and sets a self-clearing run bit. The block then asks the core for a single conversion and stores the returned 12-bit code. When the code arrives it sets a sticky completion flag, which the host polls or takes as an interrupt, and which it clears by writing a one.

The core side is a plain request/accept/done handshake. The block holds a request with a latched input selection until the core accepts it. It then waits for a done pulse carrying the result. Turning the enable bit off abandons any conversion in flight. A done pulse that arrives after that is discarded.

Top module: `sar_conv_regs`

## Requirements
- R1: After reset every readable register returns zero, and `conv_req`, `adc_on`, `conv_res12` and `irq` are low.
- R2: Control word at offset 0x00: bit 0 is enable, bit 1 is run, bit 2 is 12-bit mode and bits 7:4 are the run count; all other bits read as zero. Input-select word at 0x04: bits 4:0 are the input number and bits 10:9 are the range; all other bits read as zero. `adc_on` follows the enable bit and `conv_res12` follows the mode bit.
- R3: A control write with bits 0 and 1 both set, made while no conversion is pending or busy, raises `conv_req` on the next cycle. Run bit 1 reads 1 until the core asserts `conv_ack` together with `conv_req`, and reads 0 from the following cycle.
- R4: A control write with bit 1 set and bit 0 clear starts nothing: `conv_req` stays low and the run bit reads 0.
- R5: A `conv_done` pulse during a busy conversion stores `conv_data` into bits 11:0 of the result word at 0x4C, with bits 31:12 reading zero. It also sets bit 0 of the raw flag word at 0x5C from the next cycle.
- R6: Writing 1 to bit 0 of the clear word at 0x54 resets the raw flag. Writing 0 there has no effect, and the clear word reads as zero. When a clear and a completion fall in the same cycle, the flag stays set.
- R7: Bit 0 of the masked word at 0x58 and the `irq` output both equal the raw flag ANDed with bit 0 of the interrupt-enable word at 0x50.
- R8: A run request made while a conversion is pending or busy is ignored: no second request reaches the core.
- R9: `conv_chan` and `conv_scale` take the input-select fields when a run is accepted. Writes to the input-select word during the conversion leave them unchanged.
- R10: Clearing the enable bit during a conversion drops `conv_req` and ends the conversion. A later `conv_done` leaves the raw flag and the result word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Host write strobe, one cycle per write |
| bus_addr | input | 8 | Host byte address for reads and writes |
| bus_wdata | input | 32 | Host write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| conv_req | output | 1 | Conversion request to the ADC core |
| conv_ack | input | 1 | Core accepts the request |
| conv_chan | output | 5 | Latched input number for the core |
| conv_scale | output | 2 | Latched input range for the core |
| conv_res12 | output | 1 | 12-bit mode select for the core |
| conv_done | input | 1 | Core signals that the result is valid |
| conv_data | input | 12 | Conversion result from the core |
| adc_on | output | 1 | Converter power/enable |
| irq | output | 1 | Masked completion interrupt, active high |

## Verification
Two events can fall on the same clock edge: the host clearing the completion flag, and the core delivering a result that sets that flag. The bench provokes this by driving the clear write and the `conv_done` pulse in the same cycle. It then requires the raw flag to read 1 afterwards, so the completion must win. A run write made while the block is waiting for a result can also meet a pending conversion in the same cycle. The bench checks that no second request appears and that the input selection on the core side stays as it was.

// File: rtl/sar_conv_pkg.sv
// Shared address map, bit positions and state encoding for the
// converter control block. Offsets and bit positions are fixed because
// host software decodes them.
package sar_conv_pkg;
    localparam int OFS_CTRL   = 'h00;
    localparam int OFS_CFG    = 'h04;
    localparam int OFS_DATA   = 'h4C;
    localparam int OFS_IE     = 'h50;
    localparam int OFS_CLR    = 'h54;
    localparam int OFS_MASKED = 'h58;
    localparam int OFS_RAW    = 'h5C;

    localparam int CTL_EN_BIT  = 0;
    localparam int CTL_RUN_BIT = 1;
    localparam int CTL_RES_BIT = 2;
    localparam int CTL_CNT_LSB = 4;
    localparam int CFG_CH_LSB  = 0;
    localparam int CFG_SC_LSB  = 9;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_REQ  = 2'd1,
        SQ_BUSY = 2'd2
    } seq_state_t;
endpackage

// File: rtl/sar_conv_regfile.sv
// Host-visible register file: decodes writes, holds the control,
// input-select and interrupt-enable fields, and multiplexes read data.
// Assumes single-cycle write strobes and a combinational read path.
module sar_conv_regfile
    import sar_conv_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int RES_W  = 12,
    parameter int CH_W   = 5,
    parameter int SC_W   = 2,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              run_bit,
    input  logic [RES_W-1:0]  result,
    input  logic              raw_flag,
    input  logic              masked_flag,
    output logic              en_q,
    output logic              res12_q,
    output logic [CNT_W-1:0]  cnt_q,
    output logic [CH_W-1:0]   cfg_chan_q,
    output logic [SC_W-1:0]   cfg_scale_q,
    output logic              ie_q,
    output logic              run_wr,
    output logic              clr_wr
);
    logic at_ctrl, at_cfg, at_data, at_ie, at_clr, at_masked, at_raw;

    // Address compare, shared by the write and read paths.
    always_comb begin
        at_ctrl   = (bus_addr == ADDR_W'(OFS_CTRL));
        at_cfg    = (bus_addr == ADDR_W'(OFS_CFG));
        at_data   = (bus_addr == ADDR_W'(OFS_DATA));
        at_ie     = (bus_addr == ADDR_W'(OFS_IE));
        at_clr    = (bus_addr == ADDR_W'(OFS_CLR));
        at_masked = (bus_addr == ADDR_W'(OFS_MASKED));
        at_raw    = (bus_addr == ADDR_W'(OFS_RAW));
    end

    // Write strobes for the sequencer and the flag logic.
    always_comb begin
        run_wr = bus_wr && at_ctrl && bus_wdata[CTL_RUN_BIT] && bus_wdata[CTL_EN_BIT];
        clr_wr = bus_wr && at_clr && bus_wdata[0];
    end

    // Storage for the host-writable fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q        <= 1'b0;
            res12_q     <= 1'b0;
            cnt_q       <= '0;
            cfg_chan_q  <= '0;
            cfg_scale_q <= '0;
            ie_q        <= 1'b0;
        end else if (bus_wr) begin
            if (at_ctrl) begin
                en_q    <= bus_wdata[CTL_EN_BIT];
                res12_q <= bus_wdata[CTL_RES_BIT];
                cnt_q   <= bus_wdata[CTL_CNT_LSB +: CNT_W];
            end
            if (at_cfg) begin
                cfg_chan_q  <= bus_wdata[CFG_CH_LSB +: CH_W];
                cfg_scale_q <= bus_wdata[CFG_SC_LSB +: SC_W];
            end
            if (at_ie) begin
                ie_q <= bus_wdata[0];
            end
        end
    end

    // Read multiplexer; unmapped offsets and the clear word read zero.
    always_comb begin
        bus_rdata = '0;
        if (at_ctrl) begin
            bus_rdata[CTL_EN_BIT]              = en_q;
            bus_rdata[CTL_RUN_BIT]             = run_bit;
            bus_rdata[CTL_RES_BIT]             = res12_q;
            bus_rdata[CTL_CNT_LSB +: CNT_W]    = cnt_q;
        end else if (at_cfg) begin
            bus_rdata[CFG_CH_LSB +: CH_W]      = cfg_chan_q;
            bus_rdata[CFG_SC_LSB +: SC_W]      = cfg_scale_q;
        end else if (at_data) begin
            bus_rdata[RES_W-1:0]               = result;
        end else if (at_ie) begin
            bus_rdata[0]                       = ie_q;
        end else if (at_masked) begin
            bus_rdata[0]                       = masked_flag;
        end else if (at_raw) begin
            bus_rdata[0]                       = raw_flag;
        end
    end
endmodule

// File: rtl/sar_conv_seq.sv
// Conversion sequencer: turns an accepted run write into a request to
// the ADC core, latches the input selection, waits for the result and
// stores it. Assumes the core pulses done for one cycle per accepted
// request. A cleared enable abandons any conversion in flight.
module sar_conv_seq
    import sar_conv_pkg::*;
#(
    parameter int RES_W = 12,
    parameter int CH_W  = 5,
    parameter int SC_W  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_q,
    input  logic             run_wr,
    input  logic [CH_W-1:0]  cfg_chan,
    input  logic [SC_W-1:0]  cfg_scale,
    input  logic             conv_ack,
    input  logic             conv_done,
    input  logic [RES_W-1:0] conv_data,
    output logic             conv_req,
    output logic [CH_W-1:0]  conv_chan,
    output logic [SC_W-1:0]  conv_scale,
    output logic             run_bit,
    output logic             busy,
    output logic             done_evt,
    output logic [RES_W-1:0] result
);
    seq_state_t state;

    // State, latched selection and result register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= SQ_IDLE;
            conv_chan  <= '0;
            conv_scale <= '0;
            result     <= '0;
        end else begin
            unique case (state)
                SQ_IDLE: begin
                    if (run_wr) begin
                        state      <= SQ_REQ;
                        conv_chan  <= cfg_chan;
                        conv_scale <= cfg_scale;
                    end
                end
                SQ_REQ: begin
                    if (!en_q)         state <= SQ_IDLE;
                    else if (conv_ack) state <= SQ_BUSY;
                end
                SQ_BUSY: begin
                    if (!en_q) begin
                        state <= SQ_IDLE;
                    end else if (conv_done) begin
                        state  <= SQ_IDLE;
                        result <= conv_data;
                    end
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    // Core-facing request and status decoded from the state.
    always_comb begin
        conv_req = (state == SQ_REQ) && en_q;
        run_bit  = (state == SQ_REQ);
        busy     = (state != SQ_IDLE);
        done_evt = (state == SQ_BUSY) && en_q && conv_done;
    end
endmodule

// File: rtl/sar_conv_irq.sv
// Sticky completion flag with write-one clear and interrupt masking.
// Assumes done_evt and clr_wr are single-cycle strobes; a completion
// in the same cycle as a clear keeps the flag set.
module sar_conv_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic done_evt,
    input  logic clr_wr,
    input  logic ie_q,
    output logic raw_flag,
    output logic masked_flag
);
    // Set on completion, reset by a clear; completion has priority.
    always_ff @(posedge clk) begin
        if (!rst_n)        raw_flag <= 1'b0;
        else if (done_evt) raw_flag <= 1'b1;
        else if (clr_wr)   raw_flag <= 1'b0;
    end

    // Masked view used for the status word and the interrupt pin.
    always_comb masked_flag = raw_flag & ie_q;
endmodule

// File: rtl/sar_conv_regs.sv
// Top level of the converter control block: connects the register
// file, the conversion sequencer and the completion flag logic.
// Assumes a single host master and one ADC core on the handshake.
module sar_conv_regs
    import sar_conv_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int RES_W  = 12,
    parameter int CH_W   = 5,
    parameter int SC_W   = 2,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              conv_req,
    input  logic              conv_ack,
    output logic [CH_W-1:0]   conv_chan,
    output logic [SC_W-1:0]   conv_scale,
    output logic              conv_res12,
    input  logic              conv_done,
    input  logic [RES_W-1:0]  conv_data,
    output logic              adc_on,
    output logic              irq
);
    logic             en_q, res12_q, ie_q, run_wr, clr_wr;
    logic [CNT_W-1:0] cnt_q;
    logic [CH_W-1:0]  cfg_chan_q;
    logic [SC_W-1:0]  cfg_scale_q;
    logic             run_bit, busy, done_evt, raw_flag, masked_flag;
    logic [RES_W-1:0] result;

    sar_conv_regfile #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RES_W(RES_W),
        .CH_W(CH_W), .SC_W(SC_W), .CNT_W(CNT_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .run_bit(run_bit), .result(result),
        .raw_flag(raw_flag), .masked_flag(masked_flag),
        .en_q(en_q), .res12_q(res12_q), .cnt_q(cnt_q),
        .cfg_chan_q(cfg_chan_q), .cfg_scale_q(cfg_scale_q),
        .ie_q(ie_q), .run_wr(run_wr), .clr_wr(clr_wr)
    );

    sar_conv_seq #(
        .RES_W(RES_W), .CH_W(CH_W), .SC_W(SC_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .en_q(en_q), .run_wr(run_wr),
        .cfg_chan(cfg_chan_q), .cfg_scale(cfg_scale_q),
        .conv_ack(conv_ack), .conv_done(conv_done), .conv_data(conv_data),
        .conv_req(conv_req), .conv_chan(conv_chan), .conv_scale(conv_scale),
        .run_bit(run_bit), .busy(busy), .done_evt(done_evt), .result(result)
    );

    sar_conv_irq u_irq (
        .clk(clk), .rst_n(rst_n), .done_evt(done_evt), .clr_wr(clr_wr),
        .ie_q(ie_q), .raw_flag(raw_flag), .masked_flag(masked_flag)
    );

    // Converter-side static controls and interrupt pin.
    always_comb begin
        adc_on     = en_q;
        conv_res12 = res12_q;
        irq        = masked_flag;
    end
endmodule

// File: rtl/sar_conv_chk.sv
// Property checker for the converter control block, attached by bind.
// Observes the core handshake and the internal flag/busy state.
module sar_conv_chk #(
    parameter int CH_W = 5,
    parameter int SC_W = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic            conv_req,
    input logic            conv_ack,
    input logic [CH_W-1:0] conv_chan,
    input logic [SC_W-1:0] conv_scale,
    input logic            conv_done,
    input logic            adc_on,
    input logic            busy,
    input logic            raw_flag,
    input logic            clr_wr
);
    logic waiting;
    always_comb waiting = busy && !conv_req && adc_on;

    p_req_needs_on_r4: assert property (@(posedge clk) disable iff (!rst_n)
        conv_req |-> adc_on);
    p_ack_ends_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_req && conv_ack) |=> !conv_req);
    p_sel_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
        conv_req |=> ($stable(conv_chan) && $stable(conv_scale)));
    p_done_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (waiting && conv_done) |=> raw_flag);
    p_clear_works_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && !(waiting && conv_done)) |=> !raw_flag);
    p_off_aborts_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !adc_on) |=> !busy);
endmodule

bind sar_conv_regs sar_conv_chk #(.CH_W(CH_W), .SC_W(SC_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .conv_req(conv_req), .conv_ack(conv_ack),
    .conv_chan(conv_chan), .conv_scale(conv_scale), .conv_done(conv_done),
    .adc_on(adc_on), .busy(busy), .raw_flag(raw_flag), .clr_wr(clr_wr)
);

// File: tb/sar_conv_regs_tb_top.sv
module sar_conv_regs_tb_top;
    localparam logic [7:0] A_CTRL = 8'h00, A_CFG = 8'h04, A_DATA = 8'h4C,
                           A_IE = 8'h50, A_CLR = 8'h54, A_MSK = 8'h58, A_RAW = 8'h5C;
    localparam int NVEC = 6;
    // {input[4:0], range[1:0], sample[11:0]}
    localparam logic [18:0] VEC [NVEC] = '{
        {5'd0,  2'd0, 12'h000}, {5'd31, 2'd3, 12'hFFF}, {5'd5,  2'd1, 12'h5A5},
        {5'd16, 2'd2, 12'h7FF}, {5'd30, 2'd3, 12'h800}, {5'd14, 2'd0, 12'h001}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        conv_req, conv_res12, adc_on, irq;
    logic        conv_ack = 1'b0, conv_done = 1'b0;
    logic [4:0]  conv_chan;
    logic [1:0]  conv_scale;
    logic [11:0] conv_data = '0;
    int          n_chk = 0, n_fail = 0;
    logic [31:0] rd;
    logic [31:0] last_res = '0;

    always #4 clk = ~clk;

    sar_conv_regs dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .conv_req(conv_req),
        .conv_ack(conv_ack), .conv_chan(conv_chan), .conv_scale(conv_scale),
        .conv_res12(conv_res12), .conv_done(conv_done), .conv_data(conv_data),
        .adc_on(adc_on), .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rdreg(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic accept();
        conv_ack = 1'b1;
        @(negedge clk);
        conv_ack = 1'b0;
    endtask

    task automatic finish_conv(input logic [11:0] s);
        @(negedge clk);
        conv_done = 1'b1; conv_data = s;
        @(negedge clk);
        conv_done = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rdreg(A_CTRL, rd); check("R1 ctrl", rd, 0);
        rdreg(A_CFG, rd);  check("R1 cfg", rd, 0);
        rdreg(A_DATA, rd); check("R1 data", rd, 0);
        rdreg(A_RAW, rd);  check("R1 raw", rd, 0);
        check("R1 pins", {conv_req, adc_on, conv_res12, irq}, 0);

        // Vector table: full host sequence per entry (R3, R5, R6, R9)
        for (int i = 0; i < NVEC; i++) begin
            wr(A_CFG, {21'd0, VEC[i][13:12], 4'd0, VEC[i][18:14]});
            wr(A_CTRL, 32'h5);
            wr(A_CLR, 32'h1);
            wr(A_CTRL, 32'h7);
            check("R3 req up", conv_req, 1);
            check("R9 chan", conv_chan, VEC[i][18:14]);
            check("R9 scale", conv_scale, VEC[i][13:12]);
            rdreg(A_CTRL, rd); check("R3 run reads 1", rd, 32'h7);
            accept();
            check("R3 req down", conv_req, 0);
            rdreg(A_CTRL, rd); check("R3 run self-clear", rd, 32'h5);
            finish_conv(VEC[i][11:0]);
            last_res = {20'd0, VEC[i][11:0]};
            rdreg(A_DATA, rd); check("R5 data", rd, last_res);
            rdreg(A_RAW, rd);  check("R5 raw set", rd, 1);
            wr(A_CLR, 32'h1);
            rdreg(A_RAW, rd);  check("R6 raw cleared", rd, 0);
        end

        // R2 field layout and read-back
        wr(A_CTRL, 32'hFFFF_FFF5);
        rdreg(A_CTRL, rd); check("R2 ctrl", rd, 32'hF5);
        check("R2 pins", {adc_on, conv_res12, conv_req}, 3'b110);
        wr(A_CFG, 32'hFFFF_FFFF);
        rdreg(A_CFG, rd); check("R2 cfg", rd, 32'h61F);

        // R4 run while disabled
        wr(A_CTRL, 32'h0);
        check("R4 off", adc_on, 0);
        wr(A_CTRL, 32'h2);
        check("R4 no req", conv_req, 0);
        rdreg(A_CTRL, rd); check("R4 ctrl", rd, 0);

        // R8 and R9: second run and reselect while in flight
        wr(A_CFG, 32'h0000_0203);
        wr(A_CTRL, 32'h7);
        check("R8 req", conv_req, 1);
        wr(A_CFG, 32'h0000_0409);
        check("R9 hold chan", conv_chan, 5'd3);
        check("R9 hold scale", conv_scale, 2'd1);
        accept();
        wr(A_CTRL, 32'h7);
        check("R8 no second req", conv_req, 0);
        check("R9 chan after rerun", conv_chan, 5'd3);
        finish_conv(12'hABC);
        last_res = 32'hABC;
        rdreg(A_DATA, rd); check("R5 data", rd, last_res);

        // R7 masking while the flag is set
        check("R7 irq masked", irq, 0);
        rdreg(A_MSK, rd); check("R7 status masked", rd, 0);
        wr(A_IE, 32'h1);
        check("R7 irq on", irq, 1);
        rdreg(A_MSK, rd); check("R7 status", rd, 1);
        wr(A_IE, 32'h0);
        check("R7 irq off", irq, 0);
        rdreg(A_RAW, rd); check("R7 raw kept", rd, 1);

        // R6 clear word semantics and collision with completion
        wr(A_CLR, 32'h0);
        rdreg(A_RAW, rd); check("R6 zero write", rd, 1);
        rdreg(A_CLR, rd); check("R6 clr reads 0", rd, 0);
        wr(A_CLR, 32'h1);
        wr(A_CTRL, 32'h7);
        accept();
        @(negedge clk);
        conv_done = 1'b1; conv_data = 12'h3C3;
        bus_wr = 1'b1; bus_addr = A_CLR; bus_wdata = 32'h1;
        @(negedge clk);
        conv_done = 1'b0; bus_wr = 1'b0;
        last_res = 32'h3C3;
        rdreg(A_RAW, rd); check("R6 done wins", rd, 1);
        wr(A_CLR, 32'h1);
        rdreg(A_RAW, rd); check("R6 later clear", rd, 0);

        // R10 disable aborts; late done ignored
        wr(A_CTRL, 32'h7);
        accept();
        wr(A_CTRL, 32'h0);
        @(negedge clk);
        finish_conv(12'h123);
        rdreg(A_RAW, rd);  check("R10 raw unchanged", rd, 0);
        rdreg(A_DATA, rd); check("R10 data unchanged", rd, last_res);
        wr(A_CTRL, 32'h7);
        check("R10 idle again", conv_req, 1);
        wr(A_CTRL, 32'h0);
        check("R10 req dropped", conv_req, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule